// File: doc/BRIEF.md
# Offset-Phased Multi-Channel PWM Generator

This block drives up to sixteen pulse-width-modulated outputs, one bit per channel. Each channel runs its own incrementing cycle counter and takes three unsigned settings, all in clock cycles: a period, a high time and a start delay. Every period opens with the high phase and closes with the low phase. A period of zero turns the channel off.

One offset counter is shared by all channels. It restarts whenever the block is enabled and on every alignment strobe. A waiting channel is released on the first clock edge at which this counter has reached the channel's delay. The configuration, enable, alignment strobe and the two alignment mode bits come from a separate control block, already in this clock domain. Two settings apply at alignment. Forced alignment stops every channel at once. Otherwise a running channel completes its current period before it waits for release again. The start-at-sync bit chooses whether a channel pulses at once on release or first sits out one silent period.

Top module: `pwm_offset_gen`

## Requirements
- R1: While `en_i` is low at a clock edge, every channel and the offset counter are cleared, and all outputs are low in the following cycle.
- R2: A running channel's counter goes 0 to period-1 and then wraps to 0. Its output is high while the counter is below the latched width and low otherwise, so each period starts high.
- R3: A channel whose period input is 0 is never released. A running channel that picks up a period of 0 at its wrap stops, and its output stays low.
- R4: A width of 0 keeps the output low for the whole period. A width greater than or equal to the period keeps it high for the whole period.
- R5: The shared offset counter is 0 in the first enabled cycle and in the cycle after an alignment strobe, and it counts up by one per cycle after that. A waiting channel is released on the first edge at which the counter is greater than or equal to its offset. Counting from the first enabled edge as edge 0, a channel with offset k is first high right after edge k.
- R6: With start-at-sync low when a channel is released, its first period is entirely low and pulsing begins one period later. With it high, pulsing begins on release.
- R7: Period and width are latched on release and at each wrap, so a change made mid-period takes effect at the next period boundary.
- R8: An alignment strobe with force high stops every channel at that edge. Outputs are low in the next cycle, and channels are re-released against the restarted offset counter.
- R9: An alignment strobe with force low lets a running channel finish its current period unchanged. At the wrap it waits for release, and if its offset has already been reached it starts the next period at once.
- R10: The offset counter saturates at its all-ones value instead of wrapping, so a channel with a large offset is still released after a long idle time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PWM clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable; low holds everything cleared |
| align_i | input | 1 | One-cycle alignment strobe |
| force_i | input | 1 | Alignment stops running channels immediately |
| start_sync_i | input | 1 | Pulse on release (1) or after one silent period (0) |
| period_i | input | N_CH*CNT_W | Per-channel period, channel n at bits [n*CNT_W +: CNT_W] |
| width_i | input | N_CH*CNT_W | Per-channel high time, same packing |
| offset_i | input | N_CH*CNT_W | Per-channel start delay, same packing |
| pwm_o | output | N_CH | One PWM output per channel |

## Verification
The bench builds the block with four channels and an 8-bit counter width. The narrow width lets a few hundred idle cycles drive the offset counter into saturation, so the release of channels with offsets of 250 and 255 shows directly whether it saturates or wraps. Four channels are enough to hold a disabled channel, a zero-width channel, an always-high channel and a delayed channel side by side in one pass. A long random run then mixes alignments, forced and unforced, with enable drops and configuration changes.

// File: rtl/pwm_offset_pkg.sv
package pwm_offset_pkg;
  localparam int unsigned MAX_CH = 16;

  typedef enum logic {
    CH_WAIT = 1'b0,
    CH_RUN  = 1'b1
  } ch_state_e;
endpackage

// File: rtl/pwm_offset_cnt.sv
module pwm_offset_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             align_i,
  output logic [CNT_W-1:0] ocnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ocnt_o <= '0;
    else if (!en_i || align_i)  ocnt_o <= '0;
    else if (ocnt_o != CNT_MAX) ocnt_o <= ocnt_o + 1'b1;  // saturate, never wrap
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_offset_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             align_i,
  input  logic             force_i,
  input  logic             start_sync_i,
  input  logic [CNT_W-1:0] ocnt_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic [CNT_W-1:0] offset_i,
  output logic             run_o,
  output logic             pwm_o
);
  ch_state_e        state_q;
  logic             pend_q, skip_q;
  logic [CNT_W-1:0] cnt_q, per_q, wid_q;
  logic             release_ok, wrap;

  assign release_ok = (ocnt_i >= offset_i) && (period_i != '0) && !align_i;
  assign wrap       = (state_q == CH_RUN) && (cnt_q == per_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CH_WAIT;
      pend_q  <= 1'b0;
      skip_q  <= 1'b0;
      cnt_q   <= '0;
      per_q   <= '0;
      wid_q   <= '0;
    end else if (!en_i) begin
      state_q <= CH_WAIT;
      pend_q  <= 1'b0;
      skip_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (align_i && force_i) begin
      state_q <= CH_WAIT;
      pend_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (state_q == CH_WAIT) begin
      if (release_ok) begin
        state_q <= CH_RUN;
        cnt_q   <= '0;
        per_q   <= period_i;
        wid_q   <= width_i;
        skip_q  <= !start_sync_i;
        pend_q  <= 1'b0;
      end
    end else if (wrap) begin
      cnt_q  <= '0;
      per_q  <= period_i;
      wid_q  <= width_i;
      skip_q <= 1'b0;
      pend_q <= 1'b0;
      if (pend_q || align_i) begin
        // deferred realignment: restart only if offset already reached
        state_q <= release_ok ? CH_RUN : CH_WAIT;
        skip_q  <= !start_sync_i;
      end else if (period_i == '0) begin
        state_q <= CH_WAIT;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (align_i) pend_q <= 1'b1;
    end
  end

  assign run_o = (state_q == CH_RUN);
  assign pwm_o = run_o && !skip_q && (cnt_q < wid_q);
endmodule

// File: rtl/pwm_offset_gen.sv
module pwm_offset_gen
  import pwm_offset_pkg::*;
#(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned CNT_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic                  align_i,
  input  logic                  force_i,
  input  logic                  start_sync_i,
  input  logic [N_CH*CNT_W-1:0] period_i,
  input  logic [N_CH*CNT_W-1:0] width_i,
  input  logic [N_CH*CNT_W-1:0] offset_i,
  output logic [N_CH-1:0]       pwm_o
);
  logic [CNT_W-1:0] ocnt;
  logic [N_CH-1:0]  ch_run;

  if (N_CH < 1 || N_CH > MAX_CH) begin : g_bad_n_ch
    $error("N_CH out of range");
  end

  pwm_offset_cnt #(.CNT_W(CNT_W)) u_ocnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .align_i (align_i),
    .ocnt_o  (ocnt)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .en_i         (en_i),
      .align_i      (align_i),
      .force_i      (force_i),
      .start_sync_i (start_sync_i),
      .ocnt_i       (ocnt),
      .period_i     (period_i[c*CNT_W +: CNT_W]),
      .width_i      (width_i[c*CNT_W +: CNT_W]),
      .offset_i     (offset_i[c*CNT_W +: CNT_W]),
      .run_o        (ch_run[c]),
      .pwm_o        (pwm_o[c])
    );
  end
endmodule

// File: rtl/pwm_offset_gen_chk.sv
module pwm_offset_gen_chk #(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned CNT_W = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  en_i,
  input logic                  align_i,
  input logic                  force_i,
  input logic [N_CH*CNT_W-1:0] period_i,
  input logic [N_CH*CNT_W-1:0] offset_i,
  input logic [CNT_W-1:0]      ocnt,
  input logic [N_CH-1:0]       ch_run,
  input logic [N_CH-1:0]       pwm_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R1
  en_low_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (pwm_o == '0 && ch_run == '0 && ocnt == '0));

  // R8
  force_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && align_i && force_i) |=> (ch_run == '0 && pwm_o == '0));

  // R5
  ocnt_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && align_i) |=> (ocnt == '0));

  // R5
  ocnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !align_i && ocnt != CNT_MAX) |=> (ocnt == $past(ocnt) + 1'b1));

  // R10
  ocnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !align_i && ocnt == CNT_MAX) |=> (ocnt == CNT_MAX));

  for (genvar c = 0; c < N_CH; c++) begin : g_ch_chk
    // R3
    release_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ch_run[c]) |-> ($past(period_i[c*CNT_W +: CNT_W]) != '0));
    // R5
    release_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ch_run[c]) |-> ($past(ocnt) >= $past(offset_i[c*CNT_W +: CNT_W])));
    // R2
    idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ch_run[c] |-> !pwm_o[c]);
  end
endmodule

bind pwm_offset_gen pwm_offset_gen_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .align_i  (align_i),
  .force_i  (force_i),
  .period_i (period_i),
  .offset_i (offset_i),
  .ocnt     (ocnt),
  .ch_run   (ch_run),
  .pwm_o    (pwm_o)
);

// File: tb/pwm_offset_gen_tb.sv
module pwm_offset_gen_tb_top;
  localparam int N = 4;
  localparam int W = 8;
  localparam int OMAX = (1 << W) - 1;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           en_i = 1'b0;
  logic           align_i = 1'b0;
  logic           force_i = 1'b0;
  logic           start_sync_i = 1'b1;
  logic [N*W-1:0] period_i, width_i, offset_i;
  logic [N-1:0]   pwm_o;

  int cp[N], cw[N], co[N];
  int checks = 0;
  int errors = 0;

  // reference state
  int m_oc;
  bit m_run[N], m_pend[N], m_skip[N];
  int m_cnt[N], m_per[N], m_wid[N];

  always #10 clk_i = ~clk_i;

  always_comb begin
    for (int c = 0; c < N; c++) begin
      period_i[c*W +: W] = W'(cp[c]);
      width_i[c*W +: W]  = W'(cw[c]);
      offset_i[c*W +: W] = W'(co[c]);
    end
  end

  pwm_offset_gen #(.N_CH(N), .CNT_W(W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .align_i(align_i),
    .force_i(force_i), .start_sync_i(start_sync_i), .period_i(period_i),
    .width_i(width_i), .offset_i(offset_i), .pwm_o(pwm_o)
  );

  task automatic chk(input string req, input int ch, input bit got, input bit exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s ch%0d got %0b exp %0b at %0t", req, ch, got, exp, $time);
    end
  endtask

  // expected output j cycles after the first enabled/aligned edge
  function automatic bit exp_bit(int j, int off, int per, int wid, bit sas);
    int k;
    if (per == 0 || j < off) return 1'b0;
    k = j - off;
    if (!sas) begin
      if (k < per) return 1'b0;
      k -= per;
    end
    return (k % per) < wid;
  endfunction

  task automatic step_model();
    bit rel;
    if (!en_i) begin
      m_oc = 0;
      for (int c = 0; c < N; c++) begin
        m_run[c] = 0; m_pend[c] = 0; m_cnt[c] = 0; m_skip[c] = 0;
      end
      return;
    end
    for (int c = 0; c < N; c++) begin
      rel = (m_oc >= co[c]) && (cp[c] != 0) && !align_i;
      if (align_i && force_i) begin
        m_run[c] = 0; m_pend[c] = 0; m_cnt[c] = 0;
      end else if (!m_run[c]) begin
        if (rel) begin
          m_run[c] = 1; m_cnt[c] = 0; m_per[c] = cp[c]; m_wid[c] = cw[c];
          m_skip[c] = !start_sync_i; m_pend[c] = 0;
        end
      end else if (m_cnt[c] == m_per[c] - 1) begin
        m_cnt[c] = 0; m_per[c] = cp[c]; m_wid[c] = cw[c]; m_skip[c] = 0;
        if (m_pend[c] || align_i) begin
          m_run[c] = rel; m_skip[c] = !start_sync_i;
        end else if (cp[c] == 0) m_run[c] = 0;
        m_pend[c] = 0;
      end else begin
        m_cnt[c]++;
        if (align_i) m_pend[c] = 1;
      end
    end
    m_oc = align_i ? 0 : (m_oc == OMAX ? OMAX : m_oc + 1);
  endtask

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic set_ch(int c, int p, int w, int o);
    cp[c] = p; cw[c] = w; co[c] = o;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < N; c++) set_ch(c, 10, 7, 0);
    #35;
    // R1 reset state
    for (int c = 0; c < N; c++) chk("R1 reset", c, pwm_o[c], 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    repeat (5) begin
      cyc();
      for (int c = 0; c < N; c++) chk("R1 disabled", c, pwm_o[c], 1'b0);
    end

    // R2 R3 R4 R5: mixed channels, start-at-sync on
    set_ch(0, 10, 3, 0); set_ch(1, 5, 0, 1); set_ch(2, 4, 9, 2); set_ch(3, 0, 3, 0);
    start_sync_i = 1'b1;
    en_i = 1'b1;
    for (int j = 0; j < 30; j++) begin
      cyc();
      chk("R2", 0, pwm_o[0], exp_bit(j, 0, 10, 3, 1'b1));
      chk("R4 width0", 1, pwm_o[1], 1'b0);
      chk("R5 R4 offset wide", 2, pwm_o[2], exp_bit(j, 2, 4, 9, 1'b1));
      chk("R3 period0", 3, pwm_o[3], 1'b0);
    end

    // R6: start-at-sync off
    en_i = 1'b0; cyc();
    for (int c = 0; c < N; c++) chk("R1 drop", c, pwm_o[c], 1'b0);
    set_ch(0, 6, 2, 0); set_ch(1, 5, 3, 3); set_ch(2, 0, 1, 0); set_ch(3, 0, 1, 0);
    start_sync_i = 1'b0;
    en_i = 1'b1;
    for (int j = 0; j < 25; j++) begin
      cyc();
      chk("R6", 0, pwm_o[0], exp_bit(j, 0, 6, 2, 1'b0));
      chk("R6", 1, pwm_o[1], exp_bit(j, 3, 5, 3, 1'b0));
    end

    // R8: forced alignment
    start_sync_i = 1'b1;
    set_ch(0, 7, 4, 1); set_ch(1, 5, 2, 4);
    align_i = 1'b1; force_i = 1'b1;
    cyc();
    align_i = 1'b0; force_i = 1'b0;
    for (int c = 0; c < N; c++) chk("R8 stop", c, pwm_o[c], 1'b0);
    for (int j = 0; j < 20; j++) begin
      cyc();
      chk("R8 realign", 0, pwm_o[0], exp_bit(j, 1, 7, 4, 1'b1));
      chk("R8 realign", 1, pwm_o[1], exp_bit(j, 4, 5, 2, 1'b1));
    end

    // R7: width change mid-period applies at boundary
    en_i = 1'b0; cyc();
    set_ch(0, 10, 3, 0); set_ch(1, 0, 0, 0);
    en_i = 1'b1;
    for (int j = 0; j < 20; j++) begin
      cyc();
      if (j == 4) cw[0] = 6;
      chk("R7", 0, pwm_o[0], (j < 10) ? (j % 10 < 3) : (j % 10 < 6));
    end

    // R9: unforced alignment waits for period end
    en_i = 1'b0; cyc();
    set_ch(0, 8, 7, 0);
    en_i = 1'b1;
    for (int j = 0; j < 6; j++) cyc();
    co[0] = 3;
    align_i = 1'b1; force_i = 1'b0;
    cyc();
    align_i = 1'b0;
    chk("R9 keeps running", 0, pwm_o[0], 1'b1);
    for (int j = 7; j < 26; j++) begin
      cyc();
      chk("R9", 0, pwm_o[0], (j == 7) ? 1'b0 : exp_bit(j - 10, 0, 8, 7, 1'b1));
    end

    // R10: offset counter saturates
    en_i = 1'b0; cyc();
    for (int c = 0; c < N; c++) set_ch(c, 0, 0, 0);
    en_i = 1'b1;
    for (int j = 0; j < 300; j++) cyc();
    set_ch(0, 4, 1, 250); set_ch(1, 3, 3, OMAX);
    cyc();
    chk("R10 sat", 0, pwm_o[0], 1'b1);
    chk("R10 sat max", 1, pwm_o[1], 1'b1);
    cyc();
    chk("R10 sat", 0, pwm_o[0], 1'b0);
    chk("R10 sat max", 1, pwm_o[1], 1'b1);

    // random phase against the reference model (R2 R3 R7 R8 R9)
    void'($urandom(32'h5eed_1234));
    en_i = 1'b0;
    @(posedge clk_i); step_model(); @(negedge clk_i);
    en_i = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      align_i = ($urandom_range(39) == 0);
      force_i = $urandom_range(1);
      if ($urandom_range(199) == 0) en_i = !en_i;
      else if (!en_i && $urandom_range(3) == 0) en_i = 1'b1;
      if ($urandom_range(29) == 0) begin
        int c;
        c = $urandom_range(N - 1);
        set_ch(c, ($urandom_range(7) == 0) ? 0 : $urandom_range(12, 1),
               $urandom_range(14), $urandom_range(20));
        start_sync_i = $urandom_range(1);
      end
      @(posedge clk_i);
      step_model();
      @(negedge clk_i);
      for (int c = 0; c < N; c++)
        chk("R2 model", c, pwm_o[c], m_run[c] && !m_skip[c] && (m_cnt[c] < m_wid[c]));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule